// File: doc/BRIEF.md
# Serial Latched-Driver Load Controller

This block sits on the host side of a chain of serial-input, latched output drivers, such as those that drive the lines of a vacuum-fluorescent display. A client hands it one parallel frame together with a start request on a valid/ready handshake. The block then produces the four waveforms the driver chain needs: a serial data line, a shift clock, a latch strobe and a blanking line. It shifts the whole frame out with the most significant bit first, so that this bit ends up in the stage farthest from the controller. It then pulses the strobe to move the shift register contents into the latches. After waiting for the outputs to settle, it raises a one-cycle done pulse.

Every minimum time is given as a parameter in nanoseconds, together with the period of the system clock. Each one is rounded up to a whole number of system cycles, so no minimum is ever undercut. The phase lengths are then derived so that the data setup, data hold, clock width, clock-to-strobe gap, strobe width and output settle limits all hold. A static mode input keeps blanking high for the whole serial entry. This is meant for boards where the latch strobe is tied high, so the latches follow the shift register while it moves.

Top module: `serial_load_ctrl`

## Requirements
- R1: After reset, start_ready is 1 and drv_clk, drv_strobe, drv_blank, drv_data and done are all 0.
- R2: A frame is taken when start_valid and start_ready are both 1 at a clock edge, and start_ready is 0 from the next cycle until the frame completes. Start requests made while busy are refused, and changes on frame_in after acceptance have no effect on the bits that are shifted out.
- R3: Each frame produces exactly FRAME_W rising edges on drv_clk. The value of drv_data at the k-th rising edge is frame bit FRAME_W-k, so bit FRAME_W-1 goes first and bit 0 goes last.
- R4: drv_data is stable for at least ceil(SETUP_NS/SYS_CLK_NS) system cycles before every drv_clk rising edge.
- R5: drv_data does not change until at least ceil(HOLD_NS/SYS_CLK_NS) system cycles after a drv_clk rising edge.
- R6: Every high phase and every low phase of drv_clk lasts at least ceil(CLK_W_NS/SYS_CLK_NS) system cycles.
- R7: The drv_strobe rising edge comes at least ceil(GAP_NS/SYS_CLK_NS) system cycles after the last drv_clk rising edge.
- R8: Each frame produces exactly one drv_strobe pulse, at least ceil(STB_NS/SYS_CLK_NS) cycles wide, and drv_clk is 0 whenever drv_strobe is 1.
- R9: done is a one-cycle pulse at least ceil(SETTLE_NS/SYS_CLK_NS) cycles after the drv_strobe rising edge. start_ready is 0 while done is 1 and returns to 1 in the next cycle.
- R10: With blank_mode = 1, drv_blank is 1 at every drv_clk rising edge of a frame and 0 from the strobe onward. With blank_mode = 0, drv_blank stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_valid | input | 1 | Start request with a frame |
| start_ready | output | 1 | Controller idle, able to take a frame |
| frame_in | input | FRAME_W | Parallel frame, bit FRAME_W-1 goes to the far end of the chain |
| blank_mode | input | 1 | Hold blanking high during serial entry (static, change only while idle) |
| drv_data | output | 1 | Serial data to the first driver |
| drv_clk | output | 1 | Shift clock, shifts on its rising edge |
| drv_strobe | output | 1 | Latch strobe pulse |
| drv_blank | output | 1 | Blanking line to the drivers |
| done | output | 1 | One-cycle pulse once the outputs have settled |

## Verification
The frames used are a mixed pattern, all zeros, all ones, a lone one in the least significant bit and a lone one in the most significant bit. The lone-one frames show whether the bit order is reversed or shifted by one position. All zeros and all ones expose a data line that is stuck or never driven. One frame is run with blanking mode on, to tell the entry-blanking behaviour apart from normal operation. Another frame has a second start request and a changed frame_in while busy, which shows whether the captured frame can be disturbed. On every frame, a monitor measures each setup, hold, clock-width, gap, strobe and settle interval against the rounded-up minimums.

// File: rtl/sload_pkg.sv
package sload_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_CLK_HI,
    ST_CLK_LO,
    ST_GAP,
    ST_STB,
    ST_SETTLE,
    ST_DONE
  } sload_state_e;

  // round a time in ns up to whole system cycles
  function automatic int ns_to_cyc(input int t_ns, input int per_ns);
    return (t_ns + per_ns - 1) / per_ns;
  endfunction

  // a phase always lasts at least one cycle
  function automatic int at_least_one(input int n);
    return (n < 1) ? 1 : n;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sload_timer.sv
module sload_timer #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             phase_end
);
  logic [CNT_W-1:0] count;

  // a phase loaded with n lasts exactly n cycles
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              count <= '0;
    else if (load)           count <= load_val - CNT_W'(1);
    else if (count != '0)    count <= count - CNT_W'(1);
  end

  assign phase_end = (count == '0);
endmodule

// File: rtl/sload_shifter.sv
module sload_shifter #(
  parameter int FRAME_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [FRAME_W-1:0] frame,
  input  logic               shift,
  output logic               sout
);
  logic [FRAME_W-1:0] sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sr <= '0;
    else if (load)  sr <= frame;
    else if (shift) sr <= {sr[FRAME_W-2:0], 1'b0};
  end

  assign sout = sr[FRAME_W-1];
endmodule

// File: rtl/sload_fsm.sv
module sload_fsm
  import sload_pkg::*;
#(
  parameter int FRAME_W  = 32,
  parameter int CNT_W    = 6,
  parameter int N_SETUP  = 8,
  parameter int N_HI     = 15,
  parameter int N_LO     = 7,
  parameter int N_GAP    = 8,
  parameter int N_STB    = 10,
  parameter int N_SETTLE = 40,
  localparam int BIT_W   = $clog2(FRAME_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_valid,
  input  logic             phase_end,
  output sload_state_e     state,
  output logic             frame_take,
  output logic             bit_shift,
  output logic             timer_load,
  output logic [CNT_W-1:0] timer_val
);
  sload_state_e     state_nxt;
  logic [BIT_W-1:0] bit_idx;
  logic             last_bit;

  assign last_bit = (bit_idx == BIT_W'(FRAME_W - 1));

  always_comb begin
    state_nxt  = state;
    timer_load = 1'b0;
    timer_val  = '0;
    frame_take = 1'b0;
    bit_shift  = 1'b0;
    case (state)
      ST_IDLE: if (start_valid) begin
        state_nxt  = ST_SETUP;
        timer_load = 1'b1;
        timer_val  = CNT_W'(N_SETUP);
        frame_take = 1'b1;
      end
      ST_SETUP: if (phase_end) begin
        state_nxt  = ST_CLK_HI;
        timer_load = 1'b1;
        timer_val  = CNT_W'(N_HI);
      end
      ST_CLK_HI: if (phase_end) begin
        state_nxt  = ST_CLK_LO;
        timer_load = 1'b1;
        timer_val  = CNT_W'(N_LO);
      end
      ST_CLK_LO: if (phase_end) begin
        timer_load = 1'b1;
        if (last_bit) begin
          state_nxt = ST_GAP;
          timer_val = CNT_W'(N_GAP);
        end else begin
          state_nxt = ST_SETUP;
          timer_val = CNT_W'(N_SETUP);
          bit_shift = 1'b1;
        end
      end
      ST_GAP: if (phase_end) begin
        state_nxt  = ST_STB;
        timer_load = 1'b1;
        timer_val  = CNT_W'(N_STB);
      end
      ST_STB: if (phase_end) begin
        state_nxt  = ST_SETTLE;
        timer_load = 1'b1;
        timer_val  = CNT_W'(N_SETTLE);
      end
      ST_SETTLE: if (phase_end) state_nxt = ST_DONE;
      default:   state_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      bit_idx <= '0;
    end else begin
      state <= state_nxt;
      if (frame_take)     bit_idx <= '0;
      else if (bit_shift) bit_idx <= bit_idx + BIT_W'(1);
    end
  end
endmodule

// File: rtl/serial_load_ctrl.sv
module serial_load_ctrl
  import sload_pkg::*;
#(
  parameter int FRAME_W    = 32,
  parameter int SYS_CLK_NS = 10,
  parameter int SETUP_NS   = 75,
  parameter int HOLD_NS    = 75,
  parameter int CLK_W_NS   = 150,
  parameter int GAP_NS     = 300,
  parameter int STB_NS     = 100,
  parameter int SETTLE_NS  = 500
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_valid,
  output logic               start_ready,
  input  logic [FRAME_W-1:0] frame_in,
  input  logic               blank_mode,
  output logic               drv_data,
  output logic               drv_clk,
  output logic               drv_strobe,
  output logic               drv_blank,
  output logic               done
);
  localparam int C_SETUP  = ns_to_cyc(SETUP_NS, SYS_CLK_NS);
  localparam int C_HOLD   = ns_to_cyc(HOLD_NS, SYS_CLK_NS);
  localparam int C_CLKW   = ns_to_cyc(CLK_W_NS, SYS_CLK_NS);
  localparam int C_GAP    = ns_to_cyc(GAP_NS, SYS_CLK_NS);
  localparam int C_STB    = ns_to_cyc(STB_NS, SYS_CLK_NS);
  localparam int C_SETTLE = ns_to_cyc(SETTLE_NS, SYS_CLK_NS);

  // the low width is shared by the low phase and the next setup phase;
  // the gap and the settle time are credited with what precedes them
  localparam int N_SETUP  = at_least_one(C_SETUP);
  localparam int N_HI     = at_least_one(max2(C_CLKW, C_HOLD));
  localparam int N_LO     = at_least_one(C_CLKW - N_SETUP);
  localparam int N_GAP    = at_least_one(C_GAP - N_HI - N_LO);
  localparam int N_STB    = at_least_one(C_STB);
  localparam int N_SETTLE = at_least_one(C_SETTLE - N_STB);
  localparam int N_MAX    = max2(max2(max2(N_SETUP, N_HI), max2(N_LO, N_GAP)),
                                 max2(N_STB, N_SETTLE));
  localparam int CNT_W    = $clog2(N_MAX + 1);

  sload_state_e     state;
  logic             frame_take;
  logic             bit_shift;
  logic             phase_end;
  logic             timer_load;
  logic [CNT_W-1:0] timer_val;

  sload_fsm #(
    .FRAME_W(FRAME_W), .CNT_W(CNT_W), .N_SETUP(N_SETUP), .N_HI(N_HI),
    .N_LO(N_LO), .N_GAP(N_GAP), .N_STB(N_STB), .N_SETTLE(N_SETTLE)
  ) i_fsm (
    .clk(clk), .rst_n(rst_n), .start_valid(start_valid), .phase_end(phase_end),
    .state(state), .frame_take(frame_take), .bit_shift(bit_shift),
    .timer_load(timer_load), .timer_val(timer_val)
  );

  sload_timer #(.CNT_W(CNT_W)) i_timer (
    .clk(clk), .rst_n(rst_n), .load(timer_load), .load_val(timer_val),
    .phase_end(phase_end)
  );

  sload_shifter #(.FRAME_W(FRAME_W)) i_shifter (
    .clk(clk), .rst_n(rst_n), .load(frame_take), .frame(frame_in),
    .shift(bit_shift), .sout(drv_data)
  );

  // all outputs decode the registered state
  assign start_ready = (state == ST_IDLE);
  assign drv_clk     = (state == ST_CLK_HI);
  assign drv_strobe  = (state == ST_STB);
  assign done        = (state == ST_DONE);
  assign drv_blank   = blank_mode && (state == ST_SETUP || state == ST_CLK_HI ||
                                      state == ST_CLK_LO || state == ST_GAP);
endmodule

// File: rtl/sload_checker.sv
module sload_checker (
  input logic clk,
  input logic rst_n,
  input logic start_valid,
  input logic start_ready,
  input logic blank_mode,
  input logic drv_data,
  input logic drv_clk,
  input logic drv_strobe,
  input logic drv_blank,
  input logic done,
  input logic frame_take,
  input logic bit_shift
);
  p_accept_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start_valid && start_ready) |=> !start_ready);

  p_take_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    frame_take |-> (start_ready && start_valid));

  p_hold_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (drv_clk && $past(drv_clk)) |-> $stable(drv_data));

  p_shift_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    bit_shift |-> !drv_clk);

  p_strobe_clk_r8: assert property (@(posedge clk) disable iff (!rst_n)
    drv_strobe |-> (!drv_clk && !start_ready));

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && start_ready));

  p_blank_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !blank_mode |-> !drv_blank);

  p_blank_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
    drv_strobe |-> !drv_blank);
endmodule

bind serial_load_ctrl sload_checker i_sload_checker (
  .clk(clk), .rst_n(rst_n), .start_valid(start_valid), .start_ready(start_ready),
  .blank_mode(blank_mode), .drv_data(drv_data), .drv_clk(drv_clk),
  .drv_strobe(drv_strobe), .drv_blank(drv_blank), .done(done),
  .frame_take(frame_take), .bit_shift(bit_shift)
);

// File: tb/test_serial_load_ctrl.sv
module test_serial_load_ctrl;
  localparam int PERIOD_NS = 10;
  localparam int FW        = 32;
  localparam int SETUP_NS  = 75;
  localparam int HOLD_NS   = 75;
  localparam int CLKW_NS   = 150;
  localparam int GAP_NS    = 300;
  localparam int STB_NS    = 100;
  localparam int SETTLE_NS = 500;
  localparam int C_SETUP   = (SETUP_NS  + PERIOD_NS - 1) / PERIOD_NS;
  localparam int C_HOLD    = (HOLD_NS   + PERIOD_NS - 1) / PERIOD_NS;
  localparam int C_W       = (CLKW_NS   + PERIOD_NS - 1) / PERIOD_NS;
  localparam int C_GAP     = (GAP_NS    + PERIOD_NS - 1) / PERIOD_NS;
  localparam int C_STB     = (STB_NS    + PERIOD_NS - 1) / PERIOD_NS;
  localparam int C_SETTLE  = (SETTLE_NS + PERIOD_NS - 1) / PERIOD_NS;

  logic          clk, rst_n, start_valid, start_ready, blank_mode;
  logic [FW-1:0] frame_in;
  logic          drv_data, drv_clk, drv_strobe, drv_blank, done;

  serial_load_ctrl #(
    .FRAME_W(FW), .SYS_CLK_NS(PERIOD_NS), .SETUP_NS(SETUP_NS), .HOLD_NS(HOLD_NS),
    .CLK_W_NS(CLKW_NS), .GAP_NS(GAP_NS), .STB_NS(STB_NS), .SETTLE_NS(SETTLE_NS)
  ) i_serial_load_ctrl (
    .clk(clk), .rst_n(rst_n), .start_valid(start_valid), .start_ready(start_ready),
    .frame_in(frame_in), .blank_mode(blank_mode), .drv_data(drv_data),
    .drv_clk(drv_clk), .drv_strobe(drv_strobe), .drv_blank(drv_blank), .done(done)
  );

  initial begin
    clk = 1'b0;
    forever #(PERIOD_NS / 2) clk = ~clk;
  end

  int checks = 0;
  int errors = 0;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // waveform monitor state
  bit            mon_en = 1'b0;
  bit            mode_tb = 1'b0;
  logic          prev_clk, prev_data, prev_stb;
  int            data_run, hi_run, lo_run, since_rise, stb_run, since_stb;
  int            rises, strobes;
  logic [FW-1:0] cap;

  always @(negedge clk) begin
    if (mon_en) begin
      if (drv_data !== prev_data) begin
        check(since_rise >= C_HOLD, "R5 hold cycles", since_rise, C_HOLD);
        data_run = 1;
      end else begin
        data_run++;
      end
      if (drv_clk && !prev_clk) begin
        check(data_run - 1 >= C_SETUP, "R4 setup cycles", data_run - 1, C_SETUP);
        check(lo_run >= C_W, "R6 low width", lo_run, C_W);
        check(drv_blank == mode_tb, "R10 blank at clock rise", drv_blank, mode_tb);
        cap = {cap[FW-2:0], drv_data};
        rises++;
        since_rise = 0;
        hi_run = 1;
      end else if (!drv_clk && prev_clk) begin
        check(hi_run >= C_W, "R6 high width", hi_run, C_W);
        lo_run = 1;
        since_rise++;
      end else begin
        if (drv_clk) hi_run++; else lo_run++;
        since_rise++;
      end
      if (drv_strobe && !prev_stb) begin
        check(since_rise >= C_GAP, "R7 clock-to-strobe gap", since_rise, C_GAP);
        check(rises == FW, "R3 clock count", rises, FW);
        check(drv_blank == 1'b0, "R10 blank at strobe", drv_blank, 0);
        check(drv_clk == 1'b0, "R8 clock low at strobe", drv_clk, 0);
        strobes++;
        stb_run = 1;
        since_stb = 0;
      end else if (!drv_strobe && prev_stb) begin
        check(stb_run >= C_STB, "R8 strobe width", stb_run, C_STB);
        since_stb++;
      end else begin
        if (drv_strobe) stb_run++;
        since_stb++;
      end
      if (done) check(since_stb >= C_SETTLE, "R9 settle cycles", since_stb, C_SETTLE);
      prev_clk  = drv_clk;
      prev_data = drv_data;
      prev_stb  = drv_strobe;
    end
  end

  task automatic finish_report();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  int cycles = 0;
  always @(negedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      check(1'b0, "watchdog expired", cycles, 150000);
      finish_report();
    end
  end

  task automatic do_reset();
    rst_n = 1'b0; start_valid = 1'b0; frame_in = '0; blank_mode = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: idle state, blanking low even with the mode set
    check(start_ready == 1'b1, "R1 ready after reset", start_ready, 1);
    check(drv_clk == 1'b0, "R1 clock after reset", drv_clk, 0);
    check(drv_strobe == 1'b0, "R1 strobe after reset", drv_strobe, 0);
    check(drv_blank == 1'b0, "R1 blank after reset", drv_blank, 0);
    check(drv_data == 1'b0, "R1 data after reset", drv_data, 0);
    check(done == 1'b0, "R1 done after reset", done, 0);
    prev_clk = 1'b0; prev_data = 1'b0; prev_stb = 1'b0;
    data_run = 1; hi_run = 0; lo_run = 100000; stb_run = 0;
    since_rise = 100000; since_stb = 100000;
    mon_en = 1'b1;
  endtask

  task automatic run_frame(input logic [FW-1:0] f, input bit mode, input bit poke, input string name);
    blank_mode = mode;
    mode_tb    = mode;
    @(negedge clk);
    check(start_ready == 1'b1, {"R2 ready before ", name}, start_ready, 1);
    rises = 0; strobes = 0; cap = '0;
    start_valid = 1'b1;
    frame_in    = f;
    @(negedge clk);
    start_valid = 1'b0;
    check(start_ready == 1'b0, {"R2 busy after accept ", name}, start_ready, 0);
    frame_in = ~f;
    if (poke) begin
      repeat (40) @(negedge clk);
      start_valid = 1'b1;
      frame_in    = f ^ 32'h0F0F_00FF;
      @(negedge clk);
      check(start_ready == 1'b0, {"R2 refuse while busy ", name}, start_ready, 0);
      start_valid = 1'b0;
    end
    for (int n = 0; n < 20000 && !done; n++) @(negedge clk);
    check(done == 1'b1, {"R9 done seen ", name}, done, 1);
    check(start_ready == 1'b0, {"R9 ready low with done ", name}, start_ready, 0);
    check(cap == f, {"R3 shifted bits ", name}, cap, f);
    check(strobes == 1, {"R8 strobe count ", name}, strobes, 1);
    @(negedge clk);
    check(done == 1'b0, {"R9 done one cycle ", name}, done, 0);
    check(start_ready == 1'b1, {"R9 ready returns ", name}, start_ready, 1);
  endtask

  initial begin
    do_reset();
    run_frame(32'hA5C3_0F96, 1'b0, 1'b0, "mixed");
    run_frame(32'h0000_0000, 1'b0, 1'b0, "zeros");
    run_frame(32'hFFFF_FFFF, 1'b0, 1'b0, "ones");
    run_frame(32'h0000_0001, 1'b0, 1'b0, "lsb-one");
    run_frame(32'h8000_0000, 1'b0, 1'b0, "msb-one");
    run_frame(32'h3C5A_96E1, 1'b1, 1'b0, "blank-mode R10");
    run_frame(32'h1357_9BDF, 1'b0, 1'b1, "busy-poke R2");
    finish_report();
  end
endmodule